// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers interrupt requests from eight device lines and presents one interrupt output to a processor. A rising edge on a line latches a pending request; the output is raised for the most urgent pending line that is unmasked and not held off by an interrupt already being serviced. Line 0 is the most urgent and urgency falls as the index rises.

When the processor answers with a one-cycle acknowledge pulse, the controller moves the winning line from pending to in-service. On the next cycle it presents a vector built from a programmable base and the line index. If nothing is eligible at acknowledge time, the controller answers with the vector of line 7 and changes no state. Software ends the service of a line with an end-of-interrupt command, either naming the line or letting the controller pick the most urgent in-service line.

A second controller of the same kind can be chained in by wiring its interrupt output to the slave input, which shares the request of line 2. A small write port sets the mask and the vector base and carries the end-of-interrupt commands.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no request is pending, no line is in service, every line is masked, `int_out` is low and `vec_valid` is low, so edges arriving before any mask write never raise `int_out`.
- R2: A rising edge on a line, seen between two clock edges, sets that line's pending request; a line held high makes no further request.
- R3: `int_out` is high exactly when some line is pending, unmasked, and no line of equal or lower index is in service; it follows the registered state one cycle after the edge or write that changes it.
- R4: Among eligible lines, the one with the lowest index is granted.
- R5: An acknowledge (`inta` high for one cycle) with an eligible line sets that line's in-service bit, clears its pending bit, and in the next cycle gives `vec_valid` high for exactly one cycle with `vec_out` = {base[7:3], line index[2:0]}.
- R6: While a line is in service a new edge on it is held pending once; further edges add nothing until that request is granted.
- R7: An acknowledge while nothing is eligible returns `vec_out` = {base[7:3], 3'd7} and sets no in-service bit.
- R8: A write to address 1 with data bit 3 set is a specific end-of-interrupt; it clears the in-service bit of the line in data bits 2:0.
- R9: A write to address 1 with data bit 3 clear is a non-specific end-of-interrupt; it clears the lowest-index set in-service bit.
- R10: The slave input is combined by OR with line 2, so a rising edge of that combination requests line 2.
- R11: A write to address 0 loads the mask (bit n set masks line n); a write to address 2 loads the vector base from data bits 7:3.
- R12: An edge on a line in the same cycle as an acknowledge that grants that line leaves a new request pending after the grant; an end-of-interrupt and an acknowledge in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 8 | Device request lines, rising edge requests |
| slave_int | input | 1 | Interrupt output of a chained controller, shares line 2 |
| inta | input | 1 | Acknowledge pulse from the processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mask, 1 end-of-interrupt command, 2 vector base |
| wr_data | input | 8 | Write data |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe, vector answer for the previous acknowledge |
| vec_out | output | 8 | Vector returned on acknowledge |

## Verification
The coincidences that matter are an acknowledge landing in the same cycle as a fresh edge on the line being granted, and an acknowledge landing in the same cycle as an end-of-interrupt. Directed sequences drop and re-raise a pending line exactly in its acknowledge cycle, and issue an end-of-interrupt together with a grant. A random phase then mixes edges, acknowledges, mask writes and both kinds of end-of-interrupt freely, so these collisions recur many times. Every cycle the interrupt output and every vector answer are compared with a bench model that applies the grant and the clears from the state before the edge and then merges new edges.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NUM_LINES = 8;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int VEC_W     = 8;
    localparam int BASE_W    = VEC_W - IDX_W;
    localparam int ADDR_W    = 2;
    localparam int SPEC_BIT  = IDX_W;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASK = 2'd0,
        REG_EOI  = 2'd1,
        REG_BASE = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic             valid;
        logic             specific;
        logic [IDX_W-1:0] line;
    } eoi_cmd_t;

    // Lowest set index wins
    function automatic pick_t pick_lowest(line_vec_t v);
        pick_t p;
        p = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic line_vec_t onehot(logic [IDX_W-1:0] idx);
        return line_vec_t'(1) << idx;
    endfunction

endpackage

// File: rtl/pic_edge_detect.sv
module pic_edge_detect
    import prio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t level,
    output line_vec_t rise
);
    line_vec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/pic_ctrl_regs.sv
module pic_ctrl_regs
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    output line_vec_t         mask,
    output logic [BASE_W-1:0] base,
    output eoi_cmd_t          eoi
);
    line_vec_t         mask_q;
    logic [BASE_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            base_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_MASK: mask_q <= wr_data[NUM_LINES-1:0];
                REG_BASE: base_q <= wr_data[VEC_W-1:IDX_W];
                default:  ;
            endcase
        end
    end

    always_comb begin
        eoi          = '0;
        eoi.valid    = wr_en && (reg_addr_e'(wr_addr) == REG_EOI);
        eoi.specific = wr_data[SPEC_BIT];
        eoi.line     = wr_data[IDX_W-1:0];
    end

    assign mask = mask_q;
    assign base = base_q;
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import prio_irq_pkg::*;
(
    input  line_vec_t irr,
    input  line_vec_t isr,
    input  line_vec_t mask,
    output pick_t     grant,
    output pick_t     top_isr
);
    line_vec_t blocked;

    // A line is held off when it or any more urgent line is in service
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_block
        assign blocked[i] = |isr[i:0];
    end

    assign grant   = pick_lowest(irr & ~mask & ~blocked);
    assign top_isr = pick_lowest(isr);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int CASCADE_LINE = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 slave_int,
    input  logic                 inta,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [VEC_W-1:0]     wr_data,
    output logic                 int_out,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_out
);
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(NUM_LINES - 1);

    line_vec_t         line_in, rise, irr, isr, mask_q;
    line_vec_t         ack_set, eoi_clr;
    logic [BASE_W-1:0] base_q;
    eoi_cmd_t          eoi;
    pick_t             grant, top_isr;
    logic              ack_take;

    assign line_in = irq_lines | (line_vec_t'(slave_int) << CASCADE_LINE);

    pic_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (line_in),
        .rise  (rise)
    );

    pic_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mask    (mask_q),
        .base    (base_q),
        .eoi     (eoi)
    );

    pic_resolver u_res (
        .irr     (irr),
        .isr     (isr),
        .mask    (mask_q),
        .grant   (grant),
        .top_isr (top_isr)
    );

    assign ack_take = inta && grant.hit;
    assign ack_set  = ack_take ? onehot(grant.idx) : '0;

    always_comb begin
        eoi_clr = '0;
        if (eoi.valid) begin
            if (eoi.specific)     eoi_clr = onehot(eoi.line);
            else if (top_isr.hit) eoi_clr = onehot(top_isr.idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr       <= '0;
            isr       <= '0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            irr       <= (irr & ~ack_set) | rise;
            isr       <= (isr & ~eoi_clr) | ack_set;
            vec_valid <= inta;
            if (inta) vec_out <= {base_q, (ack_take ? grant.idx : SPUR_IDX)};
        end
    end

    assign int_out = grant.hit;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 inta,
    input logic                 wr_en,
    input logic                 int_out,
    input logic                 vec_valid,
    input logic [VEC_W-1:0]     vec_out,
    input line_vec_t            irr,
    input line_vec_t            isr,
    input line_vec_t            mask
);
    p_int_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (|(irr & ~mask)));

    p_spurious_isr_r7: assert property (@(posedge clk) disable iff (rst)
        (inta && !int_out && !wr_en) |=> (isr == $past(isr)));

    p_spurious_vec_r7: assert property (@(posedge clk) disable iff (rst)
        (inta && !int_out) |=> (vec_out[IDX_W-1:0] == IDX_W'(NUM_LINES - 1)));

    p_vec_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(inta));

    p_one_grant_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(isr & ~$past(isr)) <= 1);

    p_edge_sets_req_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_lines[0] && !$past(irq_lines[0])) |=> irr[0]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_lines (irq_lines),
    .inta      (inta),
    .wr_en     (wr_en),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .irr       (irr),
    .isr       (isr),
    .mask      (mask_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_lines = '0;
    logic       slave_int = 1'b0;
    logic       inta = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       int_out, vec_valid;
    logic [7:0] vec_out;

    int checks = 0;
    int failures = 0;

    // bench model
    logic [7:0] m_prev, m_irr, m_isr, m_mask, m_base;
    logic       m_int;

    always #2 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .slave_int (slave_int),
        .inta      (inta),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .int_out   (int_out),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    function automatic logic [7:0] eligible(logic [7:0] irr, logic [7:0] isr, logic [7:0] msk);
        logic [7:0] e;
        e = '0;
        for (int i = 0; i < 8; i++) begin
            logic held;
            held = 1'b0;
            for (int j = 0; j <= i; j++) if (isr[j]) held = 1'b1;
            e[i] = irr[i] && !msk[i] && !held;
        end
        return e;
    endfunction

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_prev = '0; m_irr = '0; m_isr = '0; m_mask = 8'hFF; m_base = '0; m_int = 1'b0;
    endtask

    // One clock: drive at negedge, update model, sample at next negedge
    task automatic cyc(input logic [7:0] l, input logic s, input logic a,
                       input logic w, input logic [1:0] ad, input logic [7:0] d,
                       input string tag);
        logic [7:0] lin, rise, ackset, eoiclr;
        int g, t;
        logic [7:0] exp_vec;
        irq_lines = l; slave_int = s; inta = a; wr_en = w; wr_addr = ad; wr_data = d;
        lin    = l | {5'b0, s, 2'b0};
        rise   = lin & ~m_prev;
        g      = lowest(eligible(m_irr, m_isr, m_mask));
        ackset = '0;
        exp_vec = {m_base[7:3], 3'd7};
        if (a && g >= 0) begin
            ackset  = 8'(1) << g;
            exp_vec = {m_base[7:3], 3'(g)};
        end
        eoiclr = '0;
        if (w && ad == 2'd1) begin
            if (d[3]) eoiclr = 8'(1) << d[2:0];
            else begin
                t = lowest(m_isr);
                if (t >= 0) eoiclr = 8'(1) << t;
            end
        end
        if (w && ad == 2'd0) m_mask = d;
        if (w && ad == 2'd2) m_base = {d[7:3], 3'b0};
        m_irr  = (m_irr & ~ackset) | rise;
        m_isr  = (m_isr & ~eoiclr) | ackset;
        m_prev = lin;
        m_int  = |eligible(m_irr, m_isr, m_mask);
        @(negedge clk);
        check(tag, "int_out", int'(int_out), int'(m_int));
        check(tag, "vec_valid", int'(vec_valid), int'(a));
        if (a) check(tag, "vec_out", int'(vec_out), int'(exp_vec));
        irq_lines = l; inta = 1'b0; wr_en = 1'b0;
    endtask

    task automatic idle(input logic [7:0] l, input string tag);
        cyc(l, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, tag);
    endtask

    task automatic ack(input logic [7:0] l, input string tag);
        cyc(l, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00, tag);
    endtask

    task automatic wr(input logic [7:0] l, input logic [1:0] ad, input logic [7:0] d, input string tag);
        cyc(l, 1'b0, 1'b0, 1'b1, ad, d, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_lines = '0; slave_int = 1'b0; inta = 1'b0; wr_en = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "int_out after reset", int'(int_out), 0);
        check("R1", "vec_valid after reset", int'(vec_valid), 0);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        @(negedge clk);
        do_reset();

        // R1: edges before unmask stay hidden
        idle(8'h20, "R1");
        idle(8'h20, "R1");
        check("R1", "int_out masked", int'(int_out), 0);
        // R11: mask and base writes
        wr(8'h20, 2'd0, 8'h00, "R11");
        check("R11", "int_out after unmask", int'(int_out), 1);
        wr(8'h20, 2'd2, 8'hAD, "R11");
        // R4: line 3 beats line 5
        idle(8'h28, "R4");
        ack(8'h28, "R4");
        check("R5", "vector line3", int'(vec_out), 8'hAB);
        // R3: line 5 held off by line 3 in service
        idle(8'h28, "R3");
        check("R3", "held off", int'(int_out), 0);
        // R2: held level no new request; R6: re-edge queues once
        idle(8'h20, "R6");
        idle(8'h28, "R6");
        idle(8'h20, "R6");
        idle(8'h28, "R6");
        // R4: line 1 preempts
        idle(8'h2A, "R4");
        ack(8'h2A, "R4");
        check("R4", "vector line1", int'(vec_out), 8'hA9);
        // R9: non-specific clears line 1
        wr(8'h2A, 2'd1, 8'h00, "R9");
        check("R9", "int after nsEOI", int'(int_out), 0);
        // R8: specific clears line 3, queued line 3 then wins
        wr(8'h2A, 2'd1, 8'h0B, "R8");
        check("R6", "queued line3 raises", int'(int_out), 1);
        ack(8'h2A, "R6");
        check("R6", "vector queued line3", int'(vec_out), 8'hAB);
        // R6: only one queued: after EOI line 5 wins, not line 3
        wr(8'h2A, 2'd1, 8'h0B, "R6");
        ack(8'h2A, "R6");
        check("R6", "single queue", int'(vec_out), 8'hAD);
        // R7: nothing eligible, spurious answer
        idle(8'h2A, "R7");
        ack(8'h2A, "R7");
        check("R7", "spurious vector", int'(vec_out), 8'hAF);
        idle(8'h2A, "R7");
        check("R7", "no grant on spurious", int'(int_out), 0);
        wr(8'h2A, 2'd1, 8'h0D, "R8");

        // R10: cascade input on line 2
        do_reset();
        wr(8'h00, 2'd0, 8'h00, "R11");
        cyc(8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, "R10");
        check("R10", "slave raises int", int'(int_out), 1);
        cyc(8'h00, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R10");
        check("R10", "slave vector", int'(vec_out), 8'h02);

        // R12: edge in the grant cycle, EOI with grant
        do_reset();
        wr(8'h00, 2'd0, 8'h00, "R11");
        idle(8'h40, "R12");
        idle(8'h00, "R12");
        ack(8'h40, "R12");
        check("R12", "grant line6", int'(vec_out), 8'h06);
        wr(8'h40, 2'd1, 8'h0E, "R12");
        check("R12", "re-request kept", int'(int_out), 1);
        idle(8'h41, "R12");
        // ack line0 while EOI line 6 in same cycle
        cyc(8'h41, 1'b0, 1'b1, 1'b1, 2'd1, 8'h0E, "R12");
        check("R12", "grant line0 with EOI", int'(vec_out), 8'h00);
        wr(8'h41, 2'd1, 8'h00, "R9");
        check("R12", "line6 back after both", int'(int_out), 1);

        // Random mix
        do_reset();
        wr(8'h00, 2'd0, 8'h00, "R11");
        for (int n = 0; n < 2000; n++) begin
            logic [7:0] l, d;
            logic s, a, w;
            logic [1:0] ad;
            int r;
            l = 8'($urandom);
            s = ($urandom % 4) == 0;
            a = ($urandom % 4) == 0;
            r = int'($urandom % 12);
            w = r < 3;
            ad = (r == 0) ? 2'd0 : 2'd1;
            d = (ad == 2'd0) ? (8'($urandom) & 8'($urandom) & 8'($urandom)) : 8'($urandom);
            cyc(l, s, a, w, ad, d, (a ? "R5" : "R3"));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule